// File: doc/BRIEF.md
# ROM Integrity-Check Sequencer

This block is the control state machine behind a boot-time ROM integrity check. After reset it lets a word counter stream the low part of the ROM into a hash engine. Then it follows the race between the two remaining activities: the counter finishing the ROM read, and the hash engine finishing the digest. When both are finished it starts an external digest comparator and waits for its verdict.

The two race states record which side finished first. A later completion from the other side is then the only legal way forward. Any completion that arrives when the block is not expecting it drives the machine into a locked state that only reset can leave. The same happens on a comparator alert or a tamper indication from the counter. A fatal alert output is raised in the same cycle as the fault. The hash engine, the comparator and the address counter are outside this block.

State codes on `state_o`: 0 = FEED_LO, 1 = FEED_HI, 2 = ROM_FIRST, 3 = HASH_FIRST, 4 = COMPARE, 5 = PASSED, 6 = LOCKED.

Top module: `rom_hash_seq`

## Requirements
- R1: The active-low asynchronous reset puts the state at FEED_LO (code 0) and holds `cmp_start_o` and `rd_req_o` low.
- R2: From FEED_LO the state moves to FEED_HI (code 1) only at an edge where `cnt_last_i`, `hash_rdy_i` and `hash_vld_o` are all high. Otherwise it stays in FEED_LO.
- R3: In FEED_HI the pair {`hash_done_i`,`cnt_done_i`} picks the next state. 01 goes to ROM_FIRST (2). 10 goes to HASH_FIRST (3). 11 goes to COMPARE (4). 00 stays. For 10 and 11 the next state is LOCKED (6) instead when `hash_err_i` is high.
- R4: ROM_FIRST waits for `hash_done_i`, then goes to COMPARE, or to LOCKED if `hash_err_i` is high. HASH_FIRST waits for `cnt_done_i`, then goes to COMPARE.
- R5: COMPARE goes to PASSED (5) when `cmp_done_i` is high. PASSED stays PASSED, and `cmp_done_i` is accepted there without fault.
- R6: Each of these events is out of order: `cmp_done_i` outside COMPARE and PASSED, `cnt_done_i` in FEED_LO, and `hash_done_i` outside FEED_HI and ROM_FIRST. Such an event raises `alert_o` in the same cycle and moves the state to LOCKED at the next edge.
- R7: `alert_o` is high whenever `cmp_alert_i` or `cnt_tamper_i` is high, or the block itself detects a fault. While `alert_o` is high, the next state is LOCKED.
- R8: LOCKED is left only by reset, whatever the inputs, and `alert_o` stays high while in LOCKED.
- R9: `hash_vld_o` is high when `hash_rdy_i` is high, or when the state is FEED_HI or HASH_FIRST.
- R10: `cmp_start_o` is high for exactly the first cycle spent in COMPARE after entering it from another state.
- R11: `rd_req_o` is high in the cycle after one in which the state was FEED_LO, `cnt_rd_i` was high and `cnt_last_i` was low. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_last_i | input | 1 | Counter is at the last low-part word |
| cnt_done_i | input | 1 | Counter has finished the whole ROM |
| cnt_rd_i | input | 1 | Counter asks for a ROM read |
| hash_rdy_i | input | 1 | Hash engine accepts input |
| hash_done_i | input | 1 | Hash engine has finished the digest |
| hash_err_i | input | 1 | Hash engine reports an error |
| cmp_done_i | input | 1 | Digest comparator has finished |
| cmp_alert_i | input | 1 | Digest comparator reports a mismatch or fault |
| cnt_tamper_i | input | 1 | Counter changed unexpectedly |
| hash_vld_o | output | 1 | Valid toward the hash engine |
| state_o | output | 3 | Current state code |
| alert_o | output | 1 | Fatal alert |
| cmp_start_o | output | 1 | One-cycle start to the comparator |
| rd_req_o | output | 1 | Registered ROM read request |

## Verification
The block has no size parameters. The bench builds it as written, with the 3-bit state code fixed by the package, and checks `state_o` directly against the codes in the requirements. The bench drives every legal path to PASSED: ROM finishing first, hash finishing first, and both finishing in the same cycle. It also drives each hash-error exit and each class of out-of-order completion from a state where it is illegal. A final run checks that LOCKED absorbs every later input.

// File: rtl/rom_hash_seq_pkg.sv
package rom_hash_seq_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_FEED_LO    = 3'd0,
        ST_FEED_HI    = 3'd1,
        ST_ROM_FIRST  = 3'd2,
        ST_HASH_FIRST = 3'd3,
        ST_COMPARE    = 3'd4,
        ST_PASSED     = 3'd5,
        ST_LOCKED     = 3'd6
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       start;
        logic       rd_req;
    } seq_regs_t;

endpackage

// File: rtl/rom_hash_seq_guard.sv
module rom_hash_seq_guard
    import rom_hash_seq_pkg::*;
(
    input  seq_state_e state_q,
    input  logic       cnt_done_i,
    input  logic       hash_done_i,
    input  logic       cmp_done_i,
    input  logic       cmp_alert_i,
    input  logic       cnt_tamper_i,
    output logic       order_err_o,
    output logic       alert_o
);

    logic cmp_early;
    logic cnt_early;
    logic hash_stray;
    logic own_alert;

    always_comb begin
        cmp_early   = cmp_done_i && !(state_q inside {ST_COMPARE, ST_PASSED});
        cnt_early   = cnt_done_i && (state_q == ST_FEED_LO);
        hash_stray  = hash_done_i && !(state_q inside {ST_FEED_HI, ST_ROM_FIRST});
        order_err_o = cmp_early | cnt_early | hash_stray;
        own_alert   = order_err_o | (state_q == ST_LOCKED);
        alert_o     = own_alert | cmp_alert_i | cnt_tamper_i;
    end

endmodule

// File: rtl/rom_hash_seq_next.sv
module rom_hash_seq_next
    import rom_hash_seq_pkg::*;
(
    input  seq_state_e state_q,
    input  logic       cnt_last_i,
    input  logic       cnt_done_i,
    input  logic       hash_rdy_i,
    input  logic       hash_done_i,
    input  logic       hash_err_i,
    input  logic       cmp_done_i,
    input  logic       force_lock_i,
    output logic       hash_vld_o,
    output seq_state_e state_d
);

    seq_state_e after_done;

    always_comb begin
        hash_vld_o = hash_rdy_i | (state_q inside {ST_FEED_HI, ST_HASH_FIRST});
        after_done = hash_err_i ? ST_LOCKED : ST_COMPARE;
        state_d    = state_q;

        unique case (state_q)
            ST_FEED_LO: begin
                if (cnt_last_i && hash_rdy_i && hash_vld_o) begin
                    state_d = ST_FEED_HI;
                end
            end
            ST_FEED_HI: begin
                unique case ({hash_done_i, cnt_done_i})
                    2'b01:   state_d = ST_ROM_FIRST;
                    2'b10:   state_d = hash_err_i ? ST_LOCKED : ST_HASH_FIRST;
                    2'b11:   state_d = after_done;
                    default: state_d = ST_FEED_HI;
                endcase
            end
            ST_ROM_FIRST: begin
                if (hash_done_i) begin
                    state_d = after_done;
                end
            end
            ST_HASH_FIRST: begin
                if (cnt_done_i) begin
                    state_d = ST_COMPARE;
                end
            end
            ST_COMPARE: begin
                if (cmp_done_i) begin
                    state_d = ST_PASSED;
                end
            end
            ST_PASSED: state_d = ST_PASSED;
            default:   state_d = ST_LOCKED;
        endcase

        if (force_lock_i) begin
            state_d = ST_LOCKED;
        end
    end

endmodule

// File: rtl/rom_hash_seq.sv
module rom_hash_seq
    import rom_hash_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_last_i,
    input  logic               cnt_done_i,
    input  logic               cnt_rd_i,
    input  logic               hash_rdy_i,
    input  logic               hash_done_i,
    input  logic               hash_err_i,
    input  logic               cmp_done_i,
    input  logic               cmp_alert_i,
    input  logic               cnt_tamper_i,
    output logic               hash_vld_o,
    output logic [STATE_W-1:0] state_o,
    output logic               alert_o,
    output logic               cmp_start_o,
    output logic               rd_req_o
);

    seq_regs_t  regs_d;
    seq_regs_t  regs_q;
    seq_state_e state_q;
    seq_state_e state_d;
    logic       order_err;
    logic       alert;

    assign state_q = regs_q.state;

    rom_hash_seq_guard u_guard (
        .state_q      (state_q),
        .cnt_done_i   (cnt_done_i),
        .hash_done_i  (hash_done_i),
        .cmp_done_i   (cmp_done_i),
        .cmp_alert_i  (cmp_alert_i),
        .cnt_tamper_i (cnt_tamper_i),
        .order_err_o  (order_err),
        .alert_o      (alert)
    );

    rom_hash_seq_next u_next (
        .state_q      (state_q),
        .cnt_last_i   (cnt_last_i),
        .cnt_done_i   (cnt_done_i),
        .hash_rdy_i   (hash_rdy_i),
        .hash_done_i  (hash_done_i),
        .hash_err_i   (hash_err_i),
        .cmp_done_i   (cmp_done_i),
        .force_lock_i (alert),
        .hash_vld_o   (hash_vld_o),
        .state_d      (state_d)
    );

    always_comb begin
        regs_d        = regs_q;
        regs_d.state  = state_d;
        regs_d.start  = (state_q != ST_COMPARE) && (state_d == ST_COMPARE);
        regs_d.rd_req = cnt_rd_i && (state_q == ST_FEED_LO) && !cnt_last_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_FEED_LO, start: 1'b0, rd_req: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o     = regs_q.state;
    assign cmp_start_o = regs_q.start;
    assign rd_req_o    = regs_q.rd_req;
    assign alert_o     = alert;

    // R8
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOCKED |=> state_q == ST_LOCKED);

    // R7
    alert_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o |=> state_q == ST_LOCKED);

    // R6
    order_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |-> alert_o);

    // R10
    start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_start_o |-> (state_q == ST_COMPARE && $past(state_q) != ST_COMPARE));

    // R11
    rdreq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> $past(state_q) == ST_FEED_LO);

    // R2
    hi_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FEED_HI && $past(state_q) == ST_FEED_LO)
        |-> $past(cnt_last_i && hash_rdy_i));

    // R5
    passed_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_PASSED |=> state_q inside {ST_PASSED, ST_LOCKED});

endmodule

// File: tb/sim_rom_hash_seq.sv
module sim_rom_hash_seq;

    localparam int PERIOD = 10;

    localparam logic [8:0] I_LAST  = 9'h001;
    localparam logic [8:0] I_CDONE = 9'h002;
    localparam logic [8:0] I_RD    = 9'h004;
    localparam logic [8:0] I_RDY   = 9'h008;
    localparam logic [8:0] I_HDONE = 9'h010;
    localparam logic [8:0] I_HERR  = 9'h020;
    localparam logic [8:0] I_CMPD  = 9'h040;
    localparam logic [8:0] I_CALR  = 9'h080;
    localparam logic [8:0] I_TAMP  = 9'h100;
    localparam logic [8:0] I_NONE  = 9'h000;

    typedef struct {
        logic [2:0] st;
        logic       al;
        logic       vl;
        logic       sp;
        logic       rq;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] iv = '0;
    logic       hash_vld, alert, cmp_start, rd_req;
    logic [2:0] state;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;
    exp_t       sb[$];

    always #(PERIOD/2) clk = ~clk;

    rom_hash_seq u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_last_i   (iv[0]),
        .cnt_done_i   (iv[1]),
        .cnt_rd_i     (iv[2]),
        .hash_rdy_i   (iv[3]),
        .hash_done_i  (iv[4]),
        .hash_err_i   (iv[5]),
        .cmp_done_i   (iv[6]),
        .cmp_alert_i  (iv[7]),
        .cnt_tamper_i (iv[8]),
        .hash_vld_o   (hash_vld),
        .state_o      (state),
        .alert_o      (alert),
        .cmp_start_o  (cmp_start),
        .rd_req_o     (rd_req)
    );

    // monitor: pops one expected item per cycle, compares mid-cycle
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (state !== e.st || alert !== e.al || hash_vld !== e.vl ||
                cmp_start !== e.sp || rd_req !== e.rq) begin
                errors++;
                $display("FAIL %s: st/al/vl/sp/rq act=%0d/%b/%b/%b/%b exp=%0d/%b/%b/%b/%b",
                         e.tag, state, alert, hash_vld, cmp_start, rd_req,
                         e.st, e.al, e.vl, e.sp, e.rq);
            end
        end
    end

    // driver: one cycle of stimulus plus the values expected during it
    task automatic cyc(input logic [8:0] v, input logic [2:0] st, input logic al,
                       input logic vl, input logic sp, input logic rq, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        iv = v;
        e.st = st; e.al = al; e.vl = vl; e.sp = sp; e.rq = rq; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        #2;
        iv = '0;
        rst_n = 1'b0;
        #1;
        checks++;
        if (state !== 3'd0 || cmp_start !== 1'b0 || rd_req !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: st/sp/rq act=%0d/%b/%b exp=0/0/0",
                     state, cmp_start, rd_req);
        end
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic to_hi();
        cyc(I_LAST | I_RDY, 3'd0, 0, 1, 0, 0, "R2 enter high part");
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // A: ROM side first, then pass, then tamper
        do_reset();
        cyc(I_RD,           3'd0, 0, 0, 0, 0, "R11 read request issued");
        cyc(I_RDY,          3'd0, 0, 1, 0, 1, "R11 read request seen");
        cyc(I_LAST | I_RDY, 3'd0, 0, 1, 0, 0, "R2 last and ready");
        cyc(I_NONE,         3'd1, 0, 1, 0, 0, "R9 high holds valid");
        cyc(I_CDONE,        3'd1, 0, 1, 0, 0, "R3 high 01");
        cyc(I_NONE,         3'd2, 0, 0, 0, 0, "R4 rom first waits");
        cyc(I_HDONE,        3'd2, 0, 0, 0, 0, "R4 rom first hash done");
        cyc(I_NONE,         3'd4, 0, 0, 1, 0, "R10 start pulse");
        cyc(I_NONE,         3'd4, 0, 0, 0, 0, "R10 start single cycle");
        cyc(I_CMPD,         3'd4, 0, 0, 0, 0, "R5 compare done");
        cyc(I_CMPD,         3'd5, 0, 0, 0, 0, "R5 passed accepts cmp done");
        cyc(I_RDY,          3'd5, 0, 1, 0, 0, "R9 valid follows ready");
        cyc(I_TAMP,         3'd5, 1, 0, 0, 0, "R7 tamper alert");
        cyc(I_NONE,         3'd6, 1, 0, 0, 0, "R8 locked alert");
        cyc(I_RDY,          3'd6, 1, 1, 0, 0, "R8 locked holds");

        // B: hash side first, comparator alert
        do_reset();
        to_hi();
        cyc(I_HDONE,        3'd1, 0, 1, 0, 0, "R3 high 10");
        cyc(I_NONE,         3'd3, 0, 1, 0, 0, "R9 hash first valid");
        cyc(I_RDY,          3'd3, 0, 1, 0, 0, "R4 hash first waits");
        cyc(I_CDONE,        3'd3, 0, 1, 0, 0, "R4 hash first cnt done");
        cyc(I_NONE,         3'd4, 0, 0, 1, 0, "R10 start after hash first");
        cyc(I_CALR,         3'd4, 1, 0, 0, 0, "R7 comparator alert");
        cyc(I_NONE,         3'd6, 1, 0, 0, 0, "R7 locked after cmp alert");

        // C: both together, then stray hash done in compare
        do_reset();
        to_hi();
        cyc(I_HDONE | I_CDONE, 3'd1, 0, 1, 0, 0, "R3 high 11");
        cyc(I_HDONE,        3'd4, 1, 0, 1, 0, "R6 hash done in compare");
        cyc(I_NONE,         3'd6, 1, 0, 0, 0, "R6 locked from compare");

        // D: both together with error
        do_reset();
        to_hi();
        cyc(I_HDONE | I_CDONE | I_HERR, 3'd1, 0, 1, 0, 0, "R3 high 11 error");
        cyc(I_NONE,         3'd6, 1, 0, 0, 0, "R3 locked no start");

        // E: hash first with error
        do_reset();
        to_hi();
        cyc(I_HDONE | I_HERR, 3'd1, 0, 1, 0, 0, "R3 high 10 error");
        cyc(I_NONE,         3'd6, 1, 0, 0, 0, "R3 locked from high");

        // F: rom first then hash error
        do_reset();
        to_hi();
        cyc(I_CDONE,        3'd1, 0, 1, 0, 0, "R3 high 01 again");
        cyc(I_HDONE | I_HERR, 3'd2, 0, 0, 0, 0, "R4 rom first error");
        cyc(I_NONE,         3'd6, 1, 0, 0, 0, "R4 locked from rom first");

        // G: last without ready, read with last
        do_reset();
        cyc(I_LAST | I_RD,  3'd0, 0, 0, 0, 0, "R2 last without ready");
        cyc(I_NONE,         3'd0, 0, 0, 0, 0, "R11 no request at last");

        // H: out-of-order events in the low part
        do_reset();
        cyc(I_CDONE,        3'd0, 1, 0, 0, 0, "R6 cnt done in low");
        cyc(I_NONE,         3'd6, 1, 0, 0, 0, "R6 locked from cnt done");
        do_reset();
        cyc(I_CMPD,         3'd0, 1, 0, 0, 0, "R6 cmp done in low");
        cyc(I_NONE,         3'd6, 1, 0, 0, 0, "R6 locked from cmp done");
        do_reset();
        cyc(I_HDONE,        3'd0, 1, 0, 0, 0, "R6 hash done in low");
        cyc(I_NONE,         3'd6, 1, 0, 0, 0, "R6 locked from hash done");
        cyc(I_CMPD | I_RDY | I_RD, 3'd6, 1, 1, 0, 0, "R8 locked ignores inputs");
        cyc(I_HDONE | I_CDONE, 3'd6, 1, 0, 0, 0, "R11 no request when locked");
        cyc(I_NONE,         3'd6, 1, 0, 0, 0, "R8 still locked");

        // I: repeated hash done in hash first
        do_reset();
        to_hi();
        cyc(I_HDONE,        3'd1, 0, 1, 0, 0, "R3 high 10 again");
        cyc(I_HDONE,        3'd3, 1, 1, 0, 0, "R6 hash done in hash first");
        cyc(I_NONE,         3'd6, 1, 0, 0, 0, "R6 locked from hash first");

        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule